// File: doc/BRIEF.md
# Word-Serial Operand Register File with Carry-In Bit Tap

This block holds the multi-word operands of a word-serial arithmetic unit. Each register stores one long operand split into m-bit words. Word 0 is the least significant word. A location is selected by a register index and a word index. The block has one write port and two read ports. All three ports are synchronous to the clock. The two read ports supply the datapath's two operands, and the datapath writes its result back through the write port.

A right shift across word boundaries needs the bit that sits just above the current word. For this reason, every read also returns bit 0 of the next more significant word of the same operand, called the overlap bit. The word loop can then shift each word right by one bit and fill in the correct top bit without any extra storage access.

The number of registers is a parameter and need not be a power of two. Register indices that fall outside the configured count are not backed by storage. Word indices beyond the operand length are treated the same way.

Top module: `rf_overlap_regfile`

## Requirements
- R1: While reset is high, and in the first cycle after reset, both read ports output a zero word and a zero overlap bit. This holds as long as the read address applied during reset is out of range.
- R2: A write with `wr_en`=1 stores `wr_data` at register `wr_reg`, word `wr_word_idx`, on the rising clock edge. A read addressed in any later cycle returns that data.
- R3: Reads have a latency of one cycle. The address is sampled at a rising edge, and the data and overlap bit are valid after that same edge until the next one.
- R4: The overlap output equals bit 0 of word (index+1) of the same register. Word 0 is the least significant word. When the top word (index WORDS-1) is read, the overlap output is 0.
- R5: The two read ports work independently. In one cycle they may address any two locations, including the same one.
- R6: A register index of NUM_REGS or higher is ignored on write, and no stored word changes. A read at such an index returns a zero word and a zero overlap bit.
- R7: A word index of WORDS or higher is ignored on write in the same way. A read at such an index returns a zero word and a zero overlap bit.
- R8: A read in the same cycle as a write returns the data stored before that write. This applies both to the addressed word and to the neighbouring word that supplies the overlap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset for the read output registers |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | REG_AW | Register index for the write |
| wr_word_idx | input | WORD_AW | Word index for the write |
| wr_data | input | WORD_W | Word to store |
| a_reg | input | REG_AW | Register index, read port A |
| a_word_idx | input | WORD_AW | Word index, read port A |
| a_data | output | WORD_W | Word read on port A |
| a_ovl | output | 1 | Bit 0 of the next higher word, port A |
| b_reg | input | REG_AW | Register index, read port B |
| b_word_idx | input | WORD_AW | Word index, read port B |
| b_data | output | WORD_W | Word read on port B |
| b_ovl | output | 1 | Bit 0 of the next higher word, port B |

## Verification
The bench drives reads of the top word, where a design that took the tap from the following register would leak bit 0 of another operand. It also reads a word and its neighbour while that neighbour is being written, where a write-first design would return the new word or the new overlap bit. It writes to the register and word indices just past the configured counts. A design that wrapped or truncated those addresses would corrupt a real location, and the bench exposes this on later reads. Finally, it reads both ports at the same location and at unrelated locations in the same cycle, to catch crossed or shared port paths.

// File: rtl/rf_ovl_pkg.sv
package rf_ovl_pkg;

  typedef struct packed {
    logic valid;
    logic top;
  } loc_flags_t;

  function automatic int idx_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/rf_ovl_locate.sv
module rf_ovl_locate
  import rf_ovl_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int WORDS    = 3,
  parameter int REG_AW   = 3,
  parameter int WORD_AW  = 2,
  parameter int IDX_W    = 4
) (
  input  logic [REG_AW-1:0]  reg_sel,
  input  logic [WORD_AW-1:0] word_sel,
  output loc_flags_t         flags,
  output logic [IDX_W-1:0]   flat_idx,
  output logic [IDX_W-1:0]   nbr_idx
);

  int reg_i;
  int word_i;

  always_comb begin
    reg_i       = int'(reg_sel);
    word_i      = int'(word_sel);
    flags.valid = (reg_i < NUM_REGS) && (word_i < WORDS);
    flags.top   = (word_i == WORDS - 1);
    flat_idx    = '0;
    nbr_idx     = '0;
    if (flags.valid) begin
      flat_idx = IDX_W'(reg_i * WORDS + word_i);
      if (!flags.top) begin
        nbr_idx = IDX_W'(reg_i * WORDS + word_i + 1);
      end
    end
  end

endmodule

// File: rtl/rf_ovl_word_bank.sv
module rf_ovl_word_bank #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 15,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [DEPTH];

  // storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_word;
    end
  end

  // registered read, old data on collision
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
    end else if (rd_en) begin
      rd_word <= mem[rd_idx];
    end else begin
      rd_word <= '0;
    end
  end

  // R6 R7: decoder must never hand out an index past the array
  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < DEPTH))
    else $error("write index outside storage");

  p_rd_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_idx) < DEPTH))
    else $error("read index outside storage");

endmodule

// File: rtl/rf_ovl_lsb_plane.sv
module rf_ovl_lsb_plane #(
  parameter int DEPTH = 15,
  parameter int IDX_W = 4,
  parameter int NRD   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             rd_en  [NRD],
  input  logic [IDX_W-1:0] rd_idx [NRD],
  output logic             rd_bit [NRD]
);

  logic bits [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bits[wr_idx] <= wr_bit;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_bit[p] <= 1'b0;
      end else if (rd_en[p]) begin
        rd_bit[p] <= bits[rd_idx[p]];
      end else begin
        rd_bit[p] <= 1'b0;
      end
    end

    p_tap_in_range_r4: assert property (@(posedge clk) disable iff (rst)
      rd_en[p] |-> (int'(rd_idx[p]) < DEPTH))
      else $error("overlap tap index outside storage");
  end

endmodule

// File: rtl/rf_overlap_regfile.sv
module rf_overlap_regfile
  import rf_ovl_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int WORDS    = 3,
  parameter int NUM_REGS = 5,
  parameter int REG_AW   = 3,
  localparam int WORD_AW = (WORDS < 2) ? 1 : $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_reg,
  input  logic [WORD_AW-1:0] wr_word_idx,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [REG_AW-1:0]  a_reg,
  input  logic [WORD_AW-1:0] a_word_idx,
  output logic [WORD_W-1:0]  a_data,
  output logic               a_ovl,
  input  logic [REG_AW-1:0]  b_reg,
  input  logic [WORD_AW-1:0] b_word_idx,
  output logic [WORD_W-1:0]  b_data,
  output logic               b_ovl
);

  localparam int DEPTH = NUM_REGS * WORDS;
  localparam int IDX_W = idx_width(DEPTH);
  localparam int NRD   = 2;

  // write side decode
  loc_flags_t       w_flags;
  logic [IDX_W-1:0] w_idx;
  logic [IDX_W-1:0] w_nbr_unused;
  logic             w_commit;

  rf_ovl_locate #(
    .NUM_REGS(NUM_REGS), .WORDS(WORDS), .REG_AW(REG_AW),
    .WORD_AW(WORD_AW), .IDX_W(IDX_W)
  ) u_wr_locate (
    .reg_sel (wr_reg),
    .word_sel(wr_word_idx),
    .flags   (w_flags),
    .flat_idx(w_idx),
    .nbr_idx (w_nbr_unused)
  );

  assign w_commit = wr_en && w_flags.valid;

  // read side, one slice per port
  logic [REG_AW-1:0]  r_reg  [NRD];
  logic [WORD_AW-1:0] r_word [NRD];
  loc_flags_t         r_flags[NRD];
  logic [IDX_W-1:0]   r_idx  [NRD];
  logic [IDX_W-1:0]   r_nbr  [NRD];
  logic               tap_en [NRD];
  logic [WORD_W-1:0]  r_data [NRD];
  logic               r_ovl  [NRD];

  assign r_reg[0]  = a_reg;
  assign r_word[0] = a_word_idx;
  assign r_reg[1]  = b_reg;
  assign r_word[1] = b_word_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_ovl_locate #(
      .NUM_REGS(NUM_REGS), .WORDS(WORDS), .REG_AW(REG_AW),
      .WORD_AW(WORD_AW), .IDX_W(IDX_W)
    ) u_rd_locate (
      .reg_sel (r_reg[p]),
      .word_sel(r_word[p]),
      .flags   (r_flags[p]),
      .flat_idx(r_idx[p]),
      .nbr_idx (r_nbr[p])
    );

    assign tap_en[p] = r_flags[p].valid && !r_flags[p].top;

    // one word array copy per read port, all written together
    rf_ovl_word_bank #(
      .WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (w_commit),
      .wr_idx (w_idx),
      .wr_word(wr_data),
      .rd_en  (r_flags[p].valid),
      .rd_idx (r_idx[p]),
      .rd_word(r_data[p])
    );

    // R6 R7: out-of-range read gives zero word and zero tap
    p_oob_zero_r6: assert property (@(posedge clk) disable iff (rst)
      !r_flags[p].valid |=> (r_data[p] == '0 && r_ovl[p] == 1'b0))
      else $error("out-of-range read not zero");

    // R4: top word has no higher neighbour
    p_top_tap_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (r_flags[p].valid && r_flags[p].top) |=> !r_ovl[p])
      else $error("top word produced overlap bit");
  end

  rf_ovl_lsb_plane #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .NRD(NRD)
  ) u_lsb (
    .clk   (clk),
    .rst   (rst),
    .wr_en (w_commit),
    .wr_idx(w_idx),
    .wr_bit(wr_data[0]),
    .rd_en (tap_en),
    .rd_idx(r_nbr),
    .rd_bit(r_ovl)
  );

  assign a_data = r_data[0];
  assign a_ovl  = r_ovl[0];
  assign b_data = r_data[1];
  assign b_ovl  = r_ovl[1];

endmodule

// File: tb/rf_overlap_regfile_test.sv
module rf_overlap_regfile_test;

  localparam int WORD_W   = 8;
  localparam int WORDS    = 3;
  localparam int NUM_REGS = 5;
  localparam int REG_AW   = 3;
  localparam int WORD_AW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [REG_AW-1:0]  wr_reg = '1;
  logic [WORD_AW-1:0] wr_word_idx = '0;
  logic [WORD_W-1:0]  wr_data = '0;
  logic [REG_AW-1:0]  a_reg = '1, b_reg = '1;
  logic [WORD_AW-1:0] a_word_idx = '0, b_word_idx = '0;
  logic [WORD_W-1:0]  a_data, b_data;
  logic a_ovl, b_ovl;

  always #10 clk = ~clk;

  rf_overlap_regfile #(
    .WORD_W(WORD_W), .WORDS(WORDS), .NUM_REGS(NUM_REGS), .REG_AW(REG_AW)
  ) uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_word_idx(wr_word_idx), .wr_data(wr_data),
    .a_reg(a_reg), .a_word_idx(a_word_idx), .a_data(a_data), .a_ovl(a_ovl),
    .b_reg(b_reg), .b_word_idx(b_word_idx), .b_data(b_data), .b_ovl(b_ovl)
  );

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] model [NUM_REGS][WORDS];
  logic [WORD_W:0] exp_a, exp_b;
  string tag_a, tag_b;
  bit have_exp = 0;

  function automatic logic [WORD_W:0] predict(input int r, input int w);
    if (r >= NUM_REGS || w >= WORDS) return '0;
    if (w == WORDS - 1) return {model[r][w], 1'b0};
    return {model[r][w], model[r][w+1][0]};
  endfunction

  function automatic string classify(input int r, input int w, input bit we,
                                     input int wr, input int ww);
    if (r >= NUM_REGS) return "R6";
    if (w >= WORDS) return "R7";
    if (we && wr == r && (ww == w || ww == w + 1)) return "R8";
    if (w == WORDS - 1) return "R2 R3 R4 top";
    return "R2 R3 R4 R5";
  endfunction

  task automatic compare(input string port, input string tag,
                         input logic [WORD_W:0] act, input logic [WORD_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual data=%h ovl=%b expected data=%h ovl=%b",
               tag, port, act[WORD_W:1], act[0], exp[WORD_W:1], exp[0]);
    end
  endtask

  task automatic step(input bit we, input int wr, input int ww, input int wd,
                      input int ar, input int aw, input int br, input int bw);
    @(negedge clk);
    if (have_exp) begin
      compare("A", tag_a, {a_data, a_ovl}, exp_a);
      compare("B", tag_b, {b_data, b_ovl}, exp_b);
    end
    wr_en       = we;
    wr_reg      = REG_AW'(wr);
    wr_word_idx = WORD_AW'(ww);
    wr_data     = WORD_W'(wd);
    a_reg = REG_AW'(ar); a_word_idx = WORD_AW'(aw);
    b_reg = REG_AW'(br); b_word_idx = WORD_AW'(bw);
    exp_a = predict(ar, aw);
    exp_b = predict(br, bw);
    tag_a = classify(ar, aw, we, wr, ww);
    tag_b = classify(br, bw, we, wr, ww);
    have_exp = 1;
    if (we && wr < NUM_REGS && ww < WORDS) model[wr][ww] = WORD_W'(wd);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: outputs zero during reset and first cycle after
    repeat (3) @(negedge clk);
    compare("A", "R1", {a_data, a_ovl}, '0);
    compare("B", "R1", {b_data, b_ovl}, '0);
    rst = 1'b0;
    @(negedge clk);
    compare("A", "R1", {a_data, a_ovl}, '0);
    compare("B", "R1", {b_data, b_ovl}, '0);

    // fill every valid location, reads aimed out of range
    for (int r = 0; r < NUM_REGS; r++)
      for (int w = 0; w < WORDS; w++)
        step(1, r, w, (r * 37 + w * 11 + 1) & 8'hff, 7, 0, 5, 1);

    // R4: overlap bit walk, odd and even neighbour LSBs
    step(1, 2, 1, 8'h01, 2, 0, 2, 1);
    step(0, 0, 0, 0,     2, 0, 2, 2);
    step(1, 2, 1, 8'hFE, 2, 0, 2, 1);
    step(1, 2, 2, 8'h81, 2, 0, 2, 2);
    // R8: read word and neighbour while they are overwritten
    step(1, 3, 0, 8'hA5, 3, 0, 3, 0);
    step(1, 3, 1, 8'h5B, 3, 0, 3, 1);
    step(0, 0, 0, 0,     3, 0, 3, 1);
    // R6 R7: out-of-range writes then sweep all locations
    step(1, 5, 0, 8'hFF, 5, 0, 7, 2);
    step(1, 7, 2, 8'hFF, 0, 3, 4, 3);
    step(1, 1, 3, 8'hFF, 1, 3, 1, 2);
    step(1, 4, 3, 8'hFF, 4, 2, 0, 0);
    for (int r = 0; r < NUM_REGS; r++)
      for (int w = 0; w < WORDS; w++)
        step(0, 0, 0, 0, r, w, NUM_REGS - 1 - r, WORDS - 1 - w);

    // R5: mixed traffic, both ports independent, collisions forced
    for (int i = 0; i < 3000; i++) begin
      int wr, ww, ar, aw, br, bw;
      bit we;
      we = $urandom_range(0, 1) == 1;
      wr = $urandom_range(0, 7);  ww = $urandom_range(0, 3);
      ar = $urandom_range(0, 7);  aw = $urandom_range(0, 3);
      br = $urandom_range(0, 7);  bw = $urandom_range(0, 3);
      if ($urandom_range(0, 4) == 0) begin ar = wr; aw = ww; end
      if ($urandom_range(0, 4) == 0) begin br = wr; bw = (ww > 0) ? ww - 1 : 0; end
      step(we, wr, ww, $urandom_range(0, 255), ar, aw, br, bw);
    end
    step(0, 0, 0, 0, 7, 0, 7, 0);
    finish_run();
  end

endmodule